// File: doc/BRIEF.md
# Two-Wire Serial Status and Interrupt Flag Unit

This block keeps the read-only status byte of a two-wire serial controller and drives its interrupt request. A separate bit-level engine reports bus events to it as single-cycle pulses: a start of transfer, a match of the device's own address, a match of the general call address, a finished data byte, a stop condition, a lost arbitration and a sampled acknowledge bit. Those pulses are qualified against two enables, acknowledge enable and general call enable, and against whether the device is currently addressed as a slave. Only qualified events set the interrupt flag. The flag clears itself when the processor reads the status byte.

Three status bits are plain mirrors of level inputs from the engine: bus busy, transmitter mode and slave mode. The other flags are held in registers. Qualified events also produce one-cycle acknowledge-interrupt and stop-interrupt pulses, which the engine uses to decide whether to hold the clock.

The block also contains a data shift register that moves bits MSB first. Its pins are plain strobes with no back-pressure. A load strobe writes a whole byte. A shift strobe moves the contents one place toward the MSB, takes the incoming bit at bit 0, and presents the current MSB as the outgoing bit. Neither side of the shift register can stall.

Top module: `twi_status_unit`

## Requirements
- R1: A synchronous active-high reset clears every registered status bit, the interrupt line, both interrupt pulses, the address-selected state and the shift register to zero.
- R2: The status byte has a fixed layout. Bit 7 is general call, bit 6 is stop seen, bit 5 is interrupt, bit 4 is transmitter mode, bit 3 is bus busy, bit 2 is arbitration lost, bit 1 is not-acknowledge and bit 0 is slave mode. Bits 4, 3 and 0 follow their level inputs in the same cycle.
- R3: An own-address pulse with acknowledge enable high sets the interrupt and gives an acknowledge-interrupt pulse in the next cycle, and it marks the device as selected. With acknowledge enable low, the pulse has no effect.
- R4: A general-call pulse sets the interrupt and status bit 7 only when both enables are high, and it gives no acknowledge-interrupt pulse. An own-address pulse or a start pulse clears bit 7.
- R5: With slave mode low, a byte-done pulse sets the interrupt and gives an acknowledge-interrupt pulse, even when arbitration is lost.
- R6: With slave mode high, a byte-done pulse sets the interrupt only while the device is selected. Otherwise it is ignored.
- R7: A stop pulse while selected sets the interrupt and status bit 6, gives a stop-interrupt pulse and ends the selection. A stop pulse while not selected has no effect.
- R8: A status read with no event pulse in the same cycle clears the interrupt flag in the next cycle. The interrupt line always equals status bit 5.
- R9: When a status read and a qualified event fall in the same cycle, the interrupt flag stays set.
- R10: An arbitration-lost pulse sets status bit 2, which then holds until a start pulse. When both pulses fall in the same cycle, the bit is set.
- R11: An acknowledge-sample pulse copies the sampled value into status bit 1, with 1 meaning not-acknowledge and 0 meaning acknowledge. The bit holds until the next sample.
- R12: The outgoing bit is shift register bit 7. A shift moves the register left and places the incoming bit at bit 0. A load takes priority over a shift in the same cycle.
- R13: A start pulse clears status bit 6 and ends the selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_start | input | 1 | Start-of-transfer pulse |
| ev_own_addr | input | 1 | Own slave address matched pulse |
| ev_gcall_addr | input | 1 | General call address matched pulse |
| ev_byte_done | input | 1 | Data byte finished pulse |
| ev_stop | input | 1 | Stop condition seen pulse |
| ev_arb_lost | input | 1 | Arbitration lost pulse |
| ev_ack_sample | input | 1 | Acknowledge bit sampled pulse |
| ack_nack | input | 1 | Sampled acknowledge value, 1 = not-acknowledge |
| lvl_busy | input | 1 | Bus busy level |
| lvl_tx | input | 1 | Transmitter mode level |
| lvl_slave | input | 1 | Slave mode level |
| en_ack | input | 1 | Acknowledge enable |
| en_gcall | input | 1 | General call enable |
| stat_rd | input | 1 | Status byte read strobe |
| stat_byte | output | 8 | Status byte |
| irq | output | 1 | Interrupt request |
| ack_irq | output | 1 | Acknowledge interrupt pulse |
| stop_irq | output | 1 | Stop interrupt pulse |
| dat_load | input | 1 | Shift register parallel load strobe |
| dat_wdata | input | SR_W | Parallel load value |
| dat_shift | input | 1 | Shift strobe |
| bit_in | input | 1 | Serial bit entering at bit 0 |
| bit_out | output | 1 | Serial bit leaving from the MSB |
| dat_rdata | output | SR_W | Shift register contents |

## Verification
Two pairs of inputs can fall in the same cycle and pull in opposite directions. The first pair is a status read that clears the interrupt flag and a qualified event that sets it. The second pair is an arbitration-lost pulse that sets status bit 2 and a start pulse that clears it. The vector table places a read in the same cycle as a selected stop pulse and in the same cycle as an own-address pulse, and it places a start pulse in the same cycle as an arbitration-lost pulse. In each case the status byte is compared one clock later, and the setting side is expected to win. A directed step also loads and shifts the data register in the same cycle and expects the loaded byte to win.

// File: rtl/twi_stat_pkg.sv
package twi_stat_pkg;

  // Status byte, MSB to LSB; the order is the software-visible layout.
  typedef struct packed {
    logic gcall;
    logic stop_seen;
    logic intr;
    logic tx_mode;
    logic busy;
    logic arb_lost;
    logic nack;
    logic slave;
  } stat_t;

  // Event pulses after qualification by enables and selection state.
  typedef struct packed {
    logic own;
    logic gcall;
    logic byte_done;
    logic stop;
  } qual_evt_t;

  localparam int STAT_W = $bits(stat_t);

endpackage

// File: rtl/twi_evt_qual.sv
module twi_evt_qual
  import twi_stat_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      ev_start,
  input  logic      ev_own_addr,
  input  logic      ev_gcall_addr,
  input  logic      ev_byte_done,
  input  logic      ev_stop,
  input  logic      lvl_slave,
  input  logic      en_ack,
  input  logic      en_gcall,
  output qual_evt_t qev,
  output logic      selected
);

  logic sel_q;
  logic addr_hit;

  // Address matches only count while acknowledging is enabled.
  always_comb begin
    qev.own       = ev_own_addr & en_ack;
    qev.gcall     = ev_gcall_addr & en_ack & en_gcall;
    // Master traffic always counts; slave traffic only once addressed.
    qev.byte_done = ev_byte_done & (~lvl_slave | sel_q);
    qev.stop      = ev_stop & sel_q;
    addr_hit      = qev.own | qev.gcall;
  end

  // Selection: entered on an accepted address, left on stop or start.
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 1'b0;
    end else if (addr_hit) begin
      sel_q <= 1'b1;
    end else if (ev_stop | ev_start) begin
      sel_q <= 1'b0;
    end
  end

  assign selected = sel_q;

endmodule

// File: rtl/twi_flag_reg.sv
module twi_flag_reg
  import twi_stat_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  qual_evt_t qev,
  input  logic      ev_start,
  input  logic      ev_arb_lost,
  input  logic      ev_ack_sample,
  input  logic      ack_nack,
  input  logic      stat_rd,
  output logic      intr,
  output logic      gcall_flag,
  output logic      stop_flag,
  output logic      arb_flag,
  output logic      nack_flag,
  output logic      ack_pulse,
  output logic      stop_pulse
);

  logic intr_q, gc_q, stop_q, arb_q, nack_q, ackp_q, stopp_q;
  logic intr_set, ack_set;

  always_comb begin
    intr_set = qev.own | qev.gcall | qev.byte_done | qev.stop;
    ack_set  = qev.own | qev.byte_done;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      intr_q  <= 1'b0;
      gc_q    <= 1'b0;
      stop_q  <= 1'b0;
      arb_q   <= 1'b0;
      nack_q  <= 1'b0;
      ackp_q  <= 1'b0;
      stopp_q <= 1'b0;
    end else begin
      // A new event outranks the clear caused by a read.
      intr_q  <= intr_set | (intr_q & ~stat_rd);

      if (qev.gcall)                gc_q <= 1'b1;
      else if (qev.own || ev_start) gc_q <= 1'b0;

      if (qev.stop)        stop_q <= 1'b1;
      else if (ev_start)   stop_q <= 1'b0;

      if (ev_arb_lost)     arb_q <= 1'b1;
      else if (ev_start)   arb_q <= 1'b0;

      if (ev_ack_sample)   nack_q <= ack_nack;

      ackp_q  <= ack_set;
      stopp_q <= qev.stop;
    end
  end

  assign intr       = intr_q;
  assign gcall_flag = gc_q;
  assign stop_flag  = stop_q;
  assign arb_flag   = arb_q;
  assign nack_flag  = nack_q;
  assign ack_pulse  = ackp_q;
  assign stop_pulse = stopp_q;

endmodule

// File: rtl/twi_shift_reg.sv
module twi_shift_reg #(
  parameter int SR_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [SR_W-1:0] wdata,
  input  logic            shift,
  input  logic            sin,
  output logic            sout,
  output logic [SR_W-1:0] q
);

  localparam int MSB = SR_W - 1;

  logic [SR_W-1:0] sr_q;
  logic [SR_W-1:0] shifted;

  // Each position takes its lower neighbour; position 0 takes the serial input.
  for (genvar i = 0; i < SR_W; i++) begin : g_pos
    if (i == 0) begin : g_lsb
      assign shifted[i] = sin;
    end else begin : g_up
      assign shifted[i] = sr_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= '0;
    end else if (load) begin
      sr_q <= wdata;
    end else if (shift) begin
      sr_q <= shifted;
    end
  end

  assign sout = sr_q[MSB];
  assign q    = sr_q;

endmodule

// File: rtl/twi_status_unit.sv
module twi_status_unit
  import twi_stat_pkg::*;
#(
  parameter int SR_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ev_start,
  input  logic            ev_own_addr,
  input  logic            ev_gcall_addr,
  input  logic            ev_byte_done,
  input  logic            ev_stop,
  input  logic            ev_arb_lost,
  input  logic            ev_ack_sample,
  input  logic            ack_nack,
  input  logic            lvl_busy,
  input  logic            lvl_tx,
  input  logic            lvl_slave,
  input  logic            en_ack,
  input  logic            en_gcall,
  input  logic            stat_rd,
  output logic [7:0]      stat_byte,
  output logic            irq,
  output logic            ack_irq,
  output logic            stop_irq,
  input  logic            dat_load,
  input  logic [SR_W-1:0] dat_wdata,
  input  logic            dat_shift,
  input  logic            bit_in,
  output logic            bit_out,
  output logic [SR_W-1:0] dat_rdata
);

  qual_evt_t qev;
  logic      selected;
  logic      intr, gc_f, stop_f, arb_f, nack_f;
  stat_t     st;

  twi_evt_qual u_qual (
    .clk           (clk),
    .rst           (rst),
    .ev_start      (ev_start),
    .ev_own_addr   (ev_own_addr),
    .ev_gcall_addr (ev_gcall_addr),
    .ev_byte_done  (ev_byte_done),
    .ev_stop       (ev_stop),
    .lvl_slave     (lvl_slave),
    .en_ack        (en_ack),
    .en_gcall      (en_gcall),
    .qev           (qev),
    .selected      (selected)
  );

  twi_flag_reg u_flags (
    .clk           (clk),
    .rst           (rst),
    .qev           (qev),
    .ev_start      (ev_start),
    .ev_arb_lost   (ev_arb_lost),
    .ev_ack_sample (ev_ack_sample),
    .ack_nack      (ack_nack),
    .stat_rd       (stat_rd),
    .intr          (intr),
    .gcall_flag    (gc_f),
    .stop_flag     (stop_f),
    .arb_flag      (arb_f),
    .nack_flag     (nack_f),
    .ack_pulse     (ack_irq),
    .stop_pulse    (stop_irq)
  );

  twi_shift_reg #(.SR_W(SR_W)) u_sr (
    .clk   (clk),
    .rst   (rst),
    .load  (dat_load),
    .wdata (dat_wdata),
    .shift (dat_shift),
    .sin   (bit_in),
    .sout  (bit_out),
    .q     (dat_rdata)
  );

  always_comb begin
    st.gcall     = gc_f;
    st.stop_seen = stop_f;
    st.intr      = intr;
    st.tx_mode   = lvl_tx;
    st.busy      = lvl_busy;
    st.arb_lost  = arb_f;
    st.nack      = nack_f;
    st.slave     = lvl_slave;
  end

  assign stat_byte = st;
  assign irq       = intr;

endmodule

// File: rtl/twi_status_unit_chk.sv
module twi_status_unit_chk #(
  parameter int SR_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            ev_start,
  input logic            ev_own_addr,
  input logic            ev_gcall_addr,
  input logic            ev_byte_done,
  input logic            ev_stop,
  input logic            ev_arb_lost,
  input logic            en_ack,
  input logic            en_gcall,
  input logic            stat_rd,
  input logic [7:0]      stat_byte,
  input logic            irq,
  input logic            ack_irq,
  input logic            stop_irq,
  input logic            dat_load,
  input logic            dat_shift,
  input logic            bit_in,
  input logic [SR_W-1:0] dat_rdata
);

  // R8: a read with no event pulse leaves the interrupt low
  a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !ev_own_addr && !ev_gcall_addr && !ev_byte_done && !ev_stop) |=> !irq);

  // R9 / R3: an accepted own address always raises the interrupt, even under a read
  a_r9_event_wins: assert property (@(posedge clk) disable iff (rst)
    (ev_own_addr && en_ack) |=> (irq && ack_irq));

  // R4: an accepted general call raises bit 7 and the interrupt
  a_r4_gcall_flag: assert property (@(posedge clk) disable iff (rst)
    (ev_gcall_addr && en_ack && en_gcall && !ev_own_addr) |=> (stat_byte[7] && irq));

  // R7: a stop interrupt pulse comes with the stop flag and the interrupt
  a_r7_stop_pulse: assert property (@(posedge clk) disable iff (rst)
    stop_irq |-> (stat_byte[6] && irq));

  // R10: arbitration lost holds until a start
  a_r10_arb_hold: assert property (@(posedge clk) disable iff (rst)
    (stat_byte[2] && !ev_start) |=> stat_byte[2]);

  // R10: arbitration lost wins over a start in the same cycle
  a_r10_arb_set: assert property (@(posedge clk) disable iff (rst)
    ev_arb_lost |=> stat_byte[2]);

  // R12: shift without load moves left and takes the serial input
  a_r12_shift_left: assert property (@(posedge clk) disable iff (rst)
    (dat_shift && !dat_load) |=> (dat_rdata == {$past(dat_rdata[SR_W-2:0]), $past(bit_in)}));

endmodule

bind twi_status_unit twi_status_unit_chk #(.SR_W(SR_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .ev_start      (ev_start),
  .ev_own_addr   (ev_own_addr),
  .ev_gcall_addr (ev_gcall_addr),
  .ev_byte_done  (ev_byte_done),
  .ev_stop       (ev_stop),
  .ev_arb_lost   (ev_arb_lost),
  .en_ack        (en_ack),
  .en_gcall      (en_gcall),
  .stat_rd       (stat_rd),
  .stat_byte     (stat_byte),
  .irq           (irq),
  .ack_irq       (ack_irq),
  .stop_irq      (stop_irq),
  .dat_load      (dat_load),
  .dat_shift     (dat_shift),
  .bit_in        (bit_in),
  .dat_rdata     (dat_rdata)
);

// File: tb/twi_status_unit_test.sv
module twi_status_unit_test;

  localparam int SR_W = 8;
  localparam int NV   = 18;

  logic clk = 1'b0;
  logic rst;
  logic ev_start, ev_own_addr, ev_gcall_addr, ev_byte_done, ev_stop;
  logic ev_arb_lost, ev_ack_sample, ack_nack;
  logic lvl_busy, lvl_tx, lvl_slave, en_ack, en_gcall, stat_rd;
  logic [7:0] stat_byte;
  logic irq, ack_irq, stop_irq;
  logic dat_load, dat_shift, bit_in, bit_out;
  logic [SR_W-1:0] dat_wdata, dat_rdata;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  twi_status_unit #(.SR_W(SR_W)) uut (.*);

  // Vector: events {start,own,gcall,byte,stop,arb,acksample,nack} | levels
  // {busy,tx,slave,ack_en,gcall_en} | read | expected status | {irq,ack,stop}
  localparam logic [24:0] VEC [0:NV-1] = '{
    {8'b0000_0000, 5'b00000, 1'b0, 8'h00, 3'b000}, // R2 idle
    {8'b0100_0000, 5'b00100, 1'b0, 8'h01, 3'b000}, // R3 own addr, ack enable low
    {8'b0100_0000, 5'b00110, 1'b0, 8'h21, 3'b110}, // R3 own addr accepted
    {8'b0000_0000, 5'b00110, 1'b1, 8'h01, 3'b000}, // R8 read clears
    {8'b0001_0011, 5'b00110, 1'b0, 8'h23, 3'b110}, // R6 R11 selected slave byte, nack
    {8'b0000_1000, 5'b00110, 1'b1, 8'h63, 3'b101}, // R7 R9 stop under read
    {8'b0000_0000, 5'b00110, 1'b1, 8'h43, 3'b000}, // R8 read
    {8'b0001_0000, 5'b00110, 1'b0, 8'h43, 3'b000}, // R6 byte while not selected
    {8'b1000_0000, 5'b10110, 1'b0, 8'h0B, 3'b000}, // R13 start clears stop flag
    {8'b0010_0000, 5'b10101, 1'b0, 8'h0B, 3'b000}, // R4 gcall, ack enable low
    {8'b0010_0000, 5'b10111, 1'b0, 8'hAB, 3'b100}, // R4 gcall accepted
    {8'b0000_0000, 5'b10111, 1'b1, 8'h8B, 3'b000}, // R8 read
    {8'b0000_0110, 5'b11011, 1'b0, 8'h9C, 3'b000}, // R10 R11 arb lost, ack
    {8'b0001_0000, 5'b11011, 1'b0, 8'hBC, 3'b110}, // R5 master byte after arb lost
    {8'b0100_0000, 5'b11011, 1'b1, 8'h3C, 3'b110}, // R9 R4 own addr under read
    {8'b1000_0100, 5'b11011, 1'b0, 8'h3C, 3'b100}, // R10 start and arb together
    {8'b1000_0000, 5'b11011, 1'b0, 8'h38, 3'b100}, // R10 start clears arb
    {8'b0000_0000, 5'b11011, 1'b1, 8'h18, 3'b000}  // R8 read
  };

  function automatic string tag_of(input int i);
    case (i)
      0: return "R2";   1, 2: return "R3";  3, 6, 11, 17: return "R8";
      4, 7: return "R6"; 5: return "R7";    8: return "R13";
      9, 10: return "R4"; 12, 15, 16: return "R10"; 13: return "R5";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    {ev_start, ev_own_addr, ev_gcall_addr, ev_byte_done, ev_stop} = '0;
    {ev_arb_lost, ev_ack_sample, ack_nack, stat_rd} = '0;
    {dat_load, dat_shift, bit_in} = '0;
    dat_wdata = '0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [SR_W-1:0] got;
    rst = 1'b1;
    idle_inputs();
    {lvl_busy, lvl_tx, lvl_slave, en_ack, en_gcall} = '0;
    repeat (3) step();
    rst = 1'b0;

    // R1 reset state
    check("R1 status", stat_byte, 8'h00);
    check("R1 pulses", {irq, ack_irq, stop_irq}, 3'b000);
    check("R1 shift", {bit_out, dat_rdata}, 9'h000);

    for (int i = 0; i < NV; i++) begin
      {ev_start, ev_own_addr, ev_gcall_addr, ev_byte_done,
       ev_stop, ev_arb_lost, ev_ack_sample, ack_nack} = VEC[i][24:17];
      {lvl_busy, lvl_tx, lvl_slave, en_ack, en_gcall} = VEC[i][16:12];
      stat_rd = VEC[i][11];
      step();
      check($sformatf("%s vector %0d status", tag_of(i), i), stat_byte, VEC[i][10:3]);
      check($sformatf("%s vector %0d irq/ack/stop", tag_of(i), i),
            {irq, ack_irq, stop_irq}, VEC[i][2:0]);
      idle_inputs();
    end

    // R10 hold over several idle cycles, then a start clears
    ev_arb_lost = 1'b1; step(); ev_arb_lost = 1'b0;
    repeat (4) step();
    check("R10 hold", stat_byte[2], 1'b1);
    ev_start = 1'b1; step(); ev_start = 1'b0;
    check("R10 start clear", stat_byte[2], 1'b0);

    // R2 mirrors follow levels in the same cycle
    {lvl_busy, lvl_tx, lvl_slave} = 3'b101;
    #1;
    check("R2 mirror", {stat_byte[4], stat_byte[3], stat_byte[0]}, 3'b011);

    // R12 load, MSB-first serial out
    dat_wdata = 8'hA5; dat_load = 1'b1; step(); dat_load = 1'b0;
    check("R12 load", {bit_out, dat_rdata}, {1'b1, 8'hA5});
    got = '0;
    for (int b = 0; b < SR_W; b++) begin
      got = {got[SR_W-2:0], bit_out};
      dat_shift = 1'b1; bit_in = 8'h3C >> (SR_W - 1 - b);
      step();
    end
    dat_shift = 1'b0; bit_in = 1'b0;
    check("R12 serial out", got, 8'hA5);
    check("R12 serial in", dat_rdata, 8'h3C);

    // R12 load beats shift in the same cycle
    dat_wdata = 8'h81; dat_load = 1'b1; dat_shift = 1'b1; bit_in = 1'b0; step();
    idle_inputs();
    check("R12 load priority", dat_rdata, 8'h81);

    // R1 reset mid-run clears flags and data
    ev_arb_lost = 1'b1; ack_nack = 1'b1; ev_ack_sample = 1'b1; step();
    idle_inputs();
    {lvl_busy, lvl_tx, lvl_slave} = 3'b000;
    rst = 1'b1; step(); rst = 1'b0;
    check("R1 reset status", stat_byte, 8'h00);
    check("R1 reset data", dat_rdata, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule